// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Bus Front End

This block is the bus-facing half of a 256-byte serial EEPROM slave. It watches the two-wire clock and data lines with a fast system clock, finds start and stop conditions, and shifts address and data bytes in. It compares the address byte against three strap inputs and two device-type codes. It returns the acknowledge by pulling the data line low through an open-drain enable. In read transfers it shifts bytes out, most significant bit first.

The block keeps no memory. Every decoded bus event goes to a memory-side controller as a one-cycle event carrying a kind code and a byte. The events are the address byte, the word address, a data byte, a read-byte request, a master acknowledge, a master no-acknowledge and a stop. For each read-byte request the controller supplies the byte on `rd_data` and advances its own pointer. The controller sends back a busy flag while its internal write runs. It also sends back a lock flag once the one-time protection command has been executed. With these two flags the front end withholds the acknowledge.

Top module: `twi_eeprom_front`

## Requirements
- R1: While reset is held and in the cycle after it is released, `sda_drive_low` is 0 and `ev_valid` is 0.
- R2: A rising data line while the clock is high is a stop. It releases the data line, sends the block to idle and emits one event of kind 7 (stop) with byte 0.
- R3: An address byte is acknowledged only when its bits [3:1] equal `strap_addr` and its bits [7:4] are 1010 (normal access) or 0110 (protection command). Bit 0 set means read. An acknowledged address emits kind 1 with the address byte.
- R4: The acknowledge is the data line pulled low across the ninth clock pulse of a received byte. The pull starts after the eighth falling edge and is released after the ninth falling edge. The drive only changes after a detected clock fall, start or stop.
- R5: After a normal write-mode address, the first byte received is emitted as kind 2 (word address). Every later byte is emitted as kind 3 (data). Each carries the received byte and is acknowledged.
- R6: After a read-mode normal address, the block emits kind 4 and shifts out `rd_data`, MSB first. A master acknowledge emits kind 5 and starts the next byte with another kind 4. A master no-acknowledge emits kind 6.
- R7: After a master no-acknowledge, the block leaves the data line released and emits no event for further clock pulses until a start or stop.
- R8: While `busy_in` is 1, no address byte is acknowledged, whatever its type or direction.
- R9: While `lock_in` is 1, an address with type 0110 is not acknowledged for either direction. Type 1010 is still acknowledged. While `lock_in` is 0, type 0110 is acknowledged.
- R10: A falling data line while the clock is high is a start. It aborts any partial byte. The next eight bits are taken as a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired value) |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| strap_addr | input | 3 | Device address straps |
| busy_in | input | 1 | Controller's internal write in progress |
| lock_in | input | 1 | Permanent protection has been set |
| rd_data | input | 8 | Byte at the controller's current read pointer |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_kind | output | 3 | Event kind: 1 addr, 2 word, 3 data, 4 read request, 5 master ack, 6 master nack, 7 stop |
| ev_data | output | 8 | Byte carried with the event |

## Verification
The hardest case to reach from the pins is a start condition that lands in the middle of a byte. The block must throw away a partly shifted address or data byte and leave the controller's pointer untouched. The stimulus clocks a few bits of a byte and then issues a start directly. It reads back through a current-address read, which shows that the aborted data byte never reached the controller. Other cases are the master no-acknowledge followed by extra clock pulses, and the busy and lock flags applied to both directions of both type codes. These run between seeded random write-then-read-back transactions.

// File: rtl/twi_fe_pkg.sv
package twi_fe_pkg;
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_DEV   = 3'd1,
    EV_WORD  = 3'd2,
    EV_DATA  = 3'd3,
    EV_RDREQ = 3'd4,
    EV_MACK  = 3'd5,
    EV_MNACK = 3'd6,
    EV_STOP  = 3'd7
  } ev_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WORD,
    PH_DATA,
    PH_READ
  } phase_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prev;

  assign raw = {sda_raw, scl_raw};

  // One synchroniser chain per bus line; index 0 is clock, 1 is data.
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[l]};
    end
    assign cur[l] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '1;
      sda_q     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      prev      <= cur;
      sda_q     <= cur[1];
      scl_rise  <= cur[0] & ~prev[0];
      scl_fall  <= ~cur[0] & prev[0];
      start_det <= cur[0] & prev[0] & prev[1] & ~cur[1];
      stop_det  <= cur[0] & prev[0] & ~prev[1] & cur[1];
    end
  end
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
  parameter int          DATA_W    = 8,
  parameter int          STRAP_W   = 3,
  parameter logic [3:0]  NORM_CODE = 4'b1010,
  parameter logic [3:0]  PROT_CODE = 4'b0110
) (
  input  logic [DATA_W-1:0]  addr_byte,
  input  logic [STRAP_W-1:0] strap,
  input  logic               busy,
  input  logic               lock,
  output logic               hit,
  output logic               is_prot,
  output logic               is_read
);
  localparam int TYPE_W = DATA_W - 1 - STRAP_W;

  logic [TYPE_W-1:0]  type_f;
  logic [STRAP_W-1:0] sel_f;
  logic               norm_m;
  logic               prot_m;

  assign type_f  = addr_byte[DATA_W-1 -: TYPE_W];
  assign sel_f   = addr_byte[STRAP_W:1];
  assign is_read = addr_byte[0];
  assign norm_m  = (type_f == TYPE_W'(NORM_CODE));
  assign prot_m  = (type_f == TYPE_W'(PROT_CODE));
  assign is_prot = prot_m;
  assign hit     = (sel_f == strap) && !busy && (norm_m || (prot_m && !lock));
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_fe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_q,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              addr_hit,
  input  logic              addr_prot,
  input  logic              addr_read,
  output logic [DATA_W-1:0] shift_byte,
  output logic              sda_drive_low,
  output logic              ev_valid,
  output ev_kind_t          ev_kind,
  output logic [DATA_W-1:0] ev_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] sh;
  logic              in_ack;
  logic              mack_slot;
  logic              mack_ok;

  assign shift_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_IDLE;
      bitcnt        <= '0;
      sh            <= '0;
      in_ack        <= 1'b0;
      mack_slot     <= 1'b0;
      mack_ok       <= 1'b0;
      sda_drive_low <= 1'b0;
      ev_valid      <= 1'b0;
      ev_kind       <= EV_NONE;
      ev_data       <= '0;
    end else begin
      ev_valid <= 1'b0;
      ev_kind  <= EV_NONE;
      if (start_det) begin
        phase         <= PH_DEV;
        bitcnt        <= '0;
        in_ack        <= 1'b0;
        mack_slot     <= 1'b0;
        mack_ok       <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        phase         <= PH_IDLE;
        bitcnt        <= '0;
        in_ack        <= 1'b0;
        mack_slot     <= 1'b0;
        mack_ok       <= 1'b0;
        sda_drive_low <= 1'b0;
        ev_valid      <= 1'b1;
        ev_kind       <= EV_STOP;
        ev_data       <= '0;
      end else if (in_ack) begin
        // End of the ninth pulse: release, or start the first read byte.
        if (scl_fall) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          if (phase == PH_READ) begin
            sh            <= rd_data;
            sda_drive_low <= ~rd_data[DATA_W-1];
            ev_valid      <= 1'b1;
            ev_kind       <= EV_RDREQ;
            ev_data       <= rd_data;
          end else begin
            sda_drive_low <= 1'b0;
          end
        end
      end else begin
        case (phase)
          PH_DEV, PH_WORD, PH_DATA: begin
            if (scl_rise && bitcnt < FULL) begin
              sh     <= {sh[DATA_W-2:0], sda_q};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              ev_data <= sh;
              if (phase == PH_DEV) begin
                if (addr_hit) begin
                  sda_drive_low <= 1'b1;
                  in_ack        <= 1'b1;
                  ev_valid      <= 1'b1;
                  ev_kind       <= EV_DEV;
                  if (!addr_read)     phase <= PH_WORD;
                  else if (addr_prot) phase <= PH_IDLE;
                  else                phase <= PH_READ;
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                sda_drive_low <= 1'b1;
                in_ack        <= 1'b1;
                ev_valid      <= 1'b1;
                ev_kind       <= (phase == PH_WORD) ? EV_WORD : EV_DATA;
                phase         <= PH_DATA;
              end
            end
          end
          PH_READ: begin
            if (scl_rise && mack_slot) begin
              mack_slot <= 1'b0;
              ev_valid  <= 1'b1;
              ev_data   <= '0;
              if (!sda_q) begin
                mack_ok <= 1'b1;
                ev_kind <= EV_MACK;
              end else begin
                ev_kind <= EV_MNACK;
                phase   <= PH_IDLE;
              end
            end else if (scl_rise && bitcnt < FULL) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && mack_ok) begin
              mack_ok       <= 1'b0;
              bitcnt        <= '0;
              sh            <= rd_data;
              sda_drive_low <= ~rd_data[DATA_W-1];
              ev_valid      <= 1'b1;
              ev_kind       <= EV_RDREQ;
              ev_data       <= rd_data;
            end else if (scl_fall && bitcnt == FULL) begin
              sda_drive_low <= 1'b0;
              mack_slot     <= 1'b1;
            end else if (scl_fall && bitcnt != '0) begin
              sh            <= {sh[DATA_W-2:0], 1'b0};
              sda_drive_low <= ~sh[DATA_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_front.sv
module twi_eeprom_front #(
  parameter int         DATA_W      = 8,
  parameter int         STRAP_W     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] NORM_CODE   = 4'b1010,
  parameter logic [3:0] PROT_CODE   = 4'b0110
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_drive_low,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               busy_in,
  input  logic               lock_in,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               ev_valid,
  output logic [2:0]         ev_kind,
  output logic [DATA_W-1:0]  ev_data
);
  import twi_fe_pkg::*;

  logic              sda_q;
  logic              scl_rise_w;
  logic              scl_fall_w;
  logic              start_w;
  logic              stop_w;
  logic [DATA_W-1:0] shift_w;
  logic              hit_w;
  logic              prot_w;
  logic              read_w;
  ev_kind_t          kind_w;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
  );

  twi_addr_match #(
    .DATA_W    (DATA_W),
    .STRAP_W   (STRAP_W),
    .NORM_CODE (NORM_CODE),
    .PROT_CODE (PROT_CODE)
  ) u_match (
    .addr_byte (shift_w),
    .strap     (strap_addr),
    .busy      (busy_in),
    .lock      (lock_in),
    .hit       (hit_w),
    .is_prot   (prot_w),
    .is_read   (read_w)
  );

  twi_byte_engine #(.DATA_W(DATA_W)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .scl_rise      (scl_rise_w),
    .scl_fall      (scl_fall_w),
    .start_det     (start_w),
    .stop_det      (stop_w),
    .sda_q         (sda_q),
    .rd_data       (rd_data),
    .addr_hit      (hit_w),
    .addr_prot     (prot_w),
    .addr_read     (read_w),
    .shift_byte    (shift_w),
    .sda_drive_low (sda_drive_low),
    .ev_valid      (ev_valid),
    .ev_kind       (kind_w),
    .ev_data       (ev_data)
  );

  assign ev_kind = kind_w;
endmodule

// File: rtl/twi_fe_checker.sv
module twi_fe_checker #(
  parameter int STRAP_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               sda_drive_low,
  input logic               ev_valid,
  input logic [2:0]         ev_kind,
  input logic [7:0]         ev_data,
  input logic [STRAP_W-1:0] strap_addr,
  input logic               busy_in,
  input logic               lock_in,
  input logic               scl_fall,
  input logic               start_det,
  input logic               stop_det
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs quiet right after reset
  always @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_reset_quiet: assert (!sda_drive_low && !ev_valid);
    end
  end

  // R2: every detected stop produces a stop event next cycle
  a_r2_stop_event: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (ev_valid && ev_kind == 3'd7));

  // R3: an acknowledged address always carries the strap value
  a_r3_strap_match: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd1) |-> (ev_data[3:1] == strap_addr));

  // R4: the drive only moves after a clock fall or a bus condition
  a_r4_drive_timing: assert property (@(posedge clk) disable iff (rst)
    (sda_drive_low != $past(sda_drive_low)) |-> $past(scl_fall || start_det || stop_det));

  // R8: no address acknowledged while busy
  a_r8_busy_silent: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd1) |-> !$past(busy_in));

  // R9: no protection-code address acknowledged once locked
  a_r9_lock_silent: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 3'd1 && ev_data[7:4] == 4'b0110) |-> !$past(lock_in));
endmodule

bind twi_eeprom_front twi_fe_checker #(.STRAP_W(STRAP_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sda_drive_low (sda_drive_low),
  .ev_valid      (ev_valid),
  .ev_kind       (ev_kind),
  .ev_data       (ev_data),
  .strap_addr    (strap_addr),
  .busy_in       (busy_in),
  .lock_in       (lock_in),
  .scl_fall      (scl_fall_w),
  .start_det     (start_w),
  .stop_det      (stop_w)
);

// File: tb/twi_eeprom_front_tb.sv
`timescale 1ns/1ps
module twi_eeprom_front_tb;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       msda = 1'b1;
  logic       busy = 1'b0;
  logic       lock = 1'b0;
  logic       sda_drive_low;
  logic       ev_valid;
  logic [2:0] ev_kind;
  logic [7:0] ev_data;
  logic [7:0] rd_data;
  wire        sda_line = msda & ~sda_drive_low;

  int checks = 0;
  int fails  = 0;

  // Controller model fed only by events
  logic [7:0] ctl_mem [256];
  logic [7:0] ctl_ptr = 8'd0;
  logic [7:0] last_dev = 8'd0;
  logic [7:0] gold [256];
  int         ev_cnt [8];
  int         ev_total = 0;
  logic [2:0] last_kind = 3'd0;
  logic [7:0] last_data = 8'd0;

  assign rd_data = ctl_mem[ctl_ptr];

  always #2.5 clk = ~clk;

  twi_eeprom_front u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .strap_addr(STRAP),
    .busy_in(busy), .lock_in(lock), .rd_data(rd_data),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data)
  );

  always @(posedge clk) begin
    if (!rst && ev_valid) begin
      ev_cnt[ev_kind] = ev_cnt[ev_kind] + 1;
      ev_total  = ev_total + 1;
      last_kind = ev_kind;
      last_data = ev_data;
      case (ev_kind)
        3'd1: last_dev = ev_data;
        3'd2: if (last_dev[7:4] == 4'b1010) ctl_ptr = ev_data;
        3'd3: if (last_dev[7:4] == 4'b1010) begin
                ctl_mem[ctl_ptr] = ev_data;
                ctl_ptr = ctl_ptr + 8'd1;
              end
        3'd4: ctl_ptr = ctl_ptr + 8'd1;
        default: ;
      endcase
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic [3:0] code, input logic [2:0] s, input bit rd);
    return {code, s, rd};
  endfunction

  task automatic bus_start();
    msda = 1'b1; tick(5);
    scl = 1'b1;  tick(10);
    msda = 1'b0; tick(10);
    scl = 1'b0;  tick(5);
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(5);
    scl = 1'b1;  tick(10);
    msda = 1'b1; tick(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      msda = b[i]; tick(5);
      scl = 1'b1;  tick(10);
      scl = 1'b0;  tick(5);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    msda = 1'b1; tick(5);
    scl = 1'b1;  tick(5);
    acked = !sda_line;
    tick(5);
    scl = 1'b0;  tick(8);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(10);
      scl = 1'b1; tick(5);
      b[i] = sda_line;
      tick(5);
      scl = 1'b0;
    end
    tick(5);
    msda = give_ack ? 1'b0 : 1'b1;
    tick(5);
    scl = 1'b1; tick(10);
    scl = 1'b0; tick(3);
    msda = 1'b1; tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit         ak;
    logic [7:0] rb;
    int         base;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      ctl_mem[i] = 8'(i) ^ 8'h5A;
      gold[i]    = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < 8; i++) ev_cnt[i] = 0;

    tick(10);
    chk(sda_drive_low == 1'b0, "R1 drive in reset", sda_drive_low, 0);
    rst = 1'b0;
    tick(1);
    chk(sda_drive_low == 1'b0 && ev_valid == 1'b0, "R1 quiet after reset", {sda_drive_low, ev_valid}, 0);
    tick(20);
    chk(ev_total == 0, "R1 no events", ev_total, 0);

    // Directed byte/page write
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b0), ak);
    chk(ak, "R3 normal write address ack", ak, 1);
    chk(last_kind == 3'd1 && last_data == devb(4'b1010, STRAP, 1'b0), "R3 address event", last_data, devb(4'b1010, STRAP, 1'b0));
    send_byte(8'h40, ak);
    chk(ak, "R4 word ack", ak, 1);
    chk(sda_drive_low == 1'b0, "R4 release after ninth pulse", sda_drive_low, 0);
    chk(last_kind == 3'd2 && last_data == 8'h40, "R5 word event", {last_kind, last_data}, {3'd2, 8'h40});
    send_byte(8'hC3, ak); gold[8'h40] = 8'hC3;
    send_byte(8'h3C, ak); gold[8'h41] = 8'h3C;
    chk(ak && last_kind == 3'd3 && last_data == 8'h3C, "R5 data event", {last_kind, last_data}, {3'd3, 8'h3C});
    base = ev_cnt[7];
    bus_stop();
    chk(ev_cnt[7] == base + 1 && last_kind == 3'd7, "R2 stop event", ev_cnt[7], base + 1);
    chk(sda_drive_low == 1'b0, "R2 released on stop", sda_drive_low, 0);

    // Random-address sequential read with master ack then nack
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b0), ak);
    send_byte(8'h40, ak);
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b1), ak);
    chk(ak, "R3 read address ack", ak, 1);
    base = ev_cnt[5];
    for (int k = 0; k < 3; k++) begin
      read_byte(k != 2, rb);
      chk(rb == gold[8'h40 + k], "R6 sequential read byte", rb, gold[8'h40 + k]);
    end
    chk(ev_cnt[5] == base + 2, "R6 master ack events", ev_cnt[5], base + 2);
    chk(last_kind == 3'd6, "R6 master nack event", last_kind, 6);
    base = ev_total;
    read_byte(1'b0, rb);
    chk(rb == 8'hFF, "R7 line released after nack", rb, 8'hFF);
    chk(ev_total == base, "R7 no events after nack", ev_total, base);
    bus_stop();

    // Current-address read continues from 0x43
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b1), ak);
    read_byte(1'b0, rb);
    chk(ak && rb == gold[8'h43], "R6 current address read", rb, gold[8'h43]);
    bus_stop();

    // Address mismatches
    bus_start();
    send_byte(devb(4'b1010, 3'b001, 1'b0), ak);
    chk(!ak, "R3 strap mismatch no ack", ak, 0);
    bus_start();
    send_byte(devb(4'b1011, STRAP, 1'b0), ak);
    chk(!ak, "R3 unknown type no ack", ak, 0);
    bus_stop();

    // Busy polling
    busy = 1'b1;
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b0), ak);
    chk(!ak, "R8 busy write address", ak, 0);
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b1), ak);
    chk(!ak, "R8 busy read address", ak, 0);
    bus_start();
    send_byte(devb(4'b0110, STRAP, 1'b0), ak);
    chk(!ak, "R8 busy protection address", ak, 0);
    busy = 1'b0;
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b0), ak);
    chk(ak, "R8 ack once idle", ak, 1);
    bus_stop();

    // Protection code, unlocked then locked
    bus_start();
    send_byte(devb(4'b0110, STRAP, 1'b0), ak);
    chk(ak, "R9 protection code ack unlocked", ak, 1);
    send_byte(8'h00, ak);
    send_byte(8'h00, ak);
    bus_stop();
    lock = 1'b1;
    bus_start();
    send_byte(devb(4'b0110, STRAP, 1'b0), ak);
    chk(!ak, "R9 locked protection write", ak, 0);
    bus_start();
    send_byte(devb(4'b0110, STRAP, 1'b1), ak);
    chk(!ak, "R9 locked protection read", ak, 0);
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b1), ak);
    read_byte(1'b0, rb);
    chk(ak, "R9 normal still acked when locked", ak, 1);
    bus_stop();
    lock = 1'b0;

    // Start aborting partial bytes
    bus_start();
    send_bits(devb(4'b1010, STRAP, 1'b0), 4);
    bus_start();
    send_byte(devb(4'b1010, STRAP, 1'b0), ak);
    chk(ak, "R10 address after aborted byte", ak, 1);
    send_byte(8'h10, ak);
    chk(last_kind == 3'd2 && last_data == 8'h10, "R10 word after abort", last_data, 8'h10);
    send_bits(8'hEE, 3);
    base = ev_total;
    bus_start();
    chk(ev_total == base, "R10 partial data dropped", ev_total, base);
    send_byte(devb(4'b1010, STRAP, 1'b1), ak);
    read_byte(1'b0, rb);
    chk(rb == gold[8'h10], "R10 pointer unchanged by aborted byte", rb, gold[8'h10]);
    bus_stop();

    // Seeded random write then read back
    for (int it = 0; it < 16; it++) begin
      logic [7:0] wa;
      int         n;
      wa = 8'($urandom);
      n  = 1 + int'($urandom % 4);
      bus_start();
      send_byte(devb(4'b1010, STRAP, 1'b0), ak);
      send_byte(wa, ak);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        send_byte(d, ak);
        chk(ak && last_kind == 3'd3 && last_data == d, "R5 random data byte", last_data, d);
        gold[8'(wa + 8'(k))] = d;
      end
      bus_stop();
      bus_start();
      send_byte(devb(4'b1010, STRAP, 1'b0), ak);
      send_byte(wa, ak);
      bus_start();
      send_byte(devb(4'b1010, STRAP, 1'b1), ak);
      for (int k = 0; k < n; k++) begin
        read_byte(k != n - 1, rb);
        chk(rb == gold[8'(wa + 8'(k))], "R6 random read back", rb, gold[8'(wa + 8'(k))]);
      end
      bus_stop();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule